// File: doc/BRIEF.md
# Receive Data-Ready and Overrun Tracker

This block keeps the receive-side status flags of a serial port: the "a character is waiting" flag and the "a character was lost" flag. It watches completed characters leaving the receive shift register. It also watches processor reads of received data and of the status register. It holds the received bytes itself, in a one-slot holding register or a small first-in first-out queue, depending on a mode input.

In single-register mode, a new character replaces an unread one, and that loss is reported as an overrun. In queue mode, characters stack up to the queue depth. Overrun is reported only when the queue is already full and one more character completes. In that case the queued bytes are kept and the new one is dropped. A data read that arrives in the same cycle as a character is served first, so the read frees a slot before the new character needs one.

Top module: `uart_rx_status`

## Requirements
- R1: During and right after reset, `data_ready` and `overrun_err` are 0 and `rd_data` is 0.
- R2: A `char_done` pulse that stores a byte sets `data_ready` on the next clock edge.
- R3: `data_ready` stays 1 until every stored byte has been consumed by `data_rd`; in queue mode bytes come out in arrival order.
- R4: With `fifo_en`=0, a character arriving while the held byte is unread (and no read in that cycle) replaces it, and `overrun_err` reads 1 after the next edge; `rd_data` then shows the new byte.
- R5: With `fifo_en`=1, up to FIFO_DEPTH (default 16) bytes are stored without overrun; one more arrival with the queue full and no read sets `overrun_err`, drops the new byte and keeps the queued bytes unchanged.
- R6: When `data_rd` and `char_done` occur in the same cycle, the read takes the oldest byte first and the new byte is stored, with no overrun, in both modes.
- R7: `overrun_err` clears on the edge after an `lsr_rd` pulse; if a new overrun occurs in that same cycle, the flag stays 1.
- R8: `data_rd` with nothing stored changes no state; `rd_data` keeps showing the last byte consumed, and later bytes are read correctly.
- R9: A change of `fifo_en` empties the storage on the next edge (`data_ready` goes to 0) and ignores `char_done` and `data_rd` in that cycle; `rd_data` then shows the last byte consumed.
- R10: `rd_data` presents the oldest unread byte combinationally, and a `data_rd` pulse consumes it at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_done | input | 1 | One-cycle pulse: a character finished in the receive shift register |
| char_data | input | DATA_W | Byte that came with `char_done` |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single-register mode |
| data_rd | input | 1 | One-cycle pulse: processor read of received data |
| lsr_rd | input | 1 | One-cycle pulse: processor read of the status register |
| rd_data | output | DATA_W | Oldest unread byte, or the last byte consumed when empty |
| data_ready | output | 1 | At least one unread byte is stored |
| overrun_err | output | 1 | A character was lost since the last status read |

## Verification
The bench builds the block with FIFO_DEPTH set to 4 and DATA_W set to 8. With a depth of 4, the full-queue boundary is reached after a handful of pulses, so the overrun, the dropped byte and the read-first rule at full occupancy are exercised directly, along with pointer wrap-around across two fills. The default depth uses the same pointer and count logic, and only the widths differ.

// File: rtl/rxst_pkg.sv
package rxst_pkg;

   // Per-cycle decision handed from the control logic to storage and flags.
   typedef struct packed {
      logic flush;      // mode changed: empty the storage
      logic pop;        // consume the oldest byte
      logic push;       // append the arriving byte
      logic overwrite;  // single-register mode: replace the unread byte
      logic ovr_set;    // a character was lost
   } rxst_ctl_t;

endpackage

// File: rtl/rxst_ctl.sv
module rxst_ctl
   import rxst_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5
) (
   input  logic             fifo_en,
   input  logic             mode_chg,
   input  logic             char_done,
   input  logic             data_rd,
   input  logic [CNT_W-1:0] cnt,
   output rxst_ctl_t        ctl
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   logic have_data;
   assign have_data = (cnt != '0);

   always_comb begin
      ctl       = '0;
      ctl.flush = mode_chg;
      if (!mode_chg) begin
         // the read is served before the arrival is judged
         ctl.pop = data_rd && have_data;
         if (char_done) begin
            if (fifo_en) begin
               if ((cnt < FULL) || ctl.pop) ctl.push = 1'b1;
               else                         ctl.ovr_set = 1'b1;
            end else begin
               if (!have_data || ctl.pop) begin
                  ctl.push = 1'b1;
               end else begin
                  ctl.overwrite = 1'b1;
                  ctl.ovr_set   = 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/rxst_store.sv
module rxst_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int PTR_W  = 4,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              pop,
   input  logic              push,
   input  logic              overwrite,
   input  logic [DATA_W-1:0] char_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  cnt
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] last_q;
   logic [PTR_W-1:0]  rd_ptr;
   logic [PTR_W-1:0]  wr_ptr;
   logic [CNT_W-1:0]  cnt_q;
   logic [PTR_W-1:0]  wsel;
   logic              we;

   // an overwrite lands on the unread slot, a push on the next free one
   assign wsel = overwrite ? rd_ptr : wr_ptr;
   assign we   = push || overwrite;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[wsel] <= char_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt_q  <= '0;
         last_q <= '0;
      end else if (flush) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (pop) begin
            rd_ptr <= rd_ptr + PTR_W'(1);
            last_q <= mem[rd_ptr];
         end
         if (push) wr_ptr <= wr_ptr + PTR_W'(1);
         cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
      end
   end

   assign cnt     = cnt_q;
   assign rd_data = (cnt_q != '0) ? mem[rd_ptr] : last_q;

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));

   // R8
   empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !flush) |=> $stable(rd_ptr));

   // R9
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt_q == '0));

endmodule

// File: rtl/rxst_flags.sv
module rxst_flags #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ovr_set,
   input  logic             lsr_rd,
   input  logic [CNT_W-1:0] cnt,
   output logic             data_ready,
   output logic             overrun_err
);

   logic ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovr_q <= 1'b0;
      else if (ovr_set) ovr_q <= 1'b1;   // a fresh loss outranks the clear
      else if (lsr_rd)  ovr_q <= 1'b0;
   end

   assign data_ready  = (cnt != '0);
   assign overrun_err = ovr_q;

   // R7
   ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !lsr_rd) |=> ovr_q);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
   import rxst_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_done,
   input  logic [DATA_W-1:0] char_data,
   input  logic              fifo_en,
   input  logic              data_rd,
   input  logic              lsr_rd,
   output logic [DATA_W-1:0] rd_data,
   output logic              data_ready,
   output logic              overrun_err
);

   localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
   localparam int CNT_W = PTR_W + 1;

   generate
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
   endgenerate

   logic             fifo_en_q;
   logic             mode_chg;
   logic [CNT_W-1:0] cnt;
   rxst_ctl_t        ctl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fifo_en_q <= 1'b0;
      else        fifo_en_q <= fifo_en;
   end

   assign mode_chg = fifo_en ^ fifo_en_q;

   rxst_ctl #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_ctl (
      .fifo_en   (fifo_en),
      .mode_chg  (mode_chg),
      .char_done (char_done),
      .data_rd   (data_rd),
      .cnt       (cnt),
      .ctl       (ctl)
   );

   rxst_store #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (ctl.flush),
      .pop       (ctl.pop),
      .push      (ctl.push),
      .overwrite (ctl.overwrite),
      .char_data (char_data),
      .rd_data   (rd_data),
      .cnt       (cnt)
   );

   rxst_flags #(.CNT_W(CNT_W)) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .ovr_set     (ctl.ovr_set),
      .lsr_rd      (lsr_rd),
      .cnt         (cnt),
      .data_ready  (data_ready),
      .overrun_err (overrun_err)
   );

   // R2
   ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_ready) |-> $past(char_done));

   // R7
   ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_err) |-> $past(char_done));

   // R7
   ovr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(overrun_err) |-> $past(lsr_rd));

   // R4
   single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en_q |-> (cnt <= CNT_W'(1)));

   // R6
   read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && !mode_chg && char_done && data_rd && data_ready) |=> !$rose(overrun_err));

endmodule

// File: tb/uart_rx_status_test.sv
`timescale 1ns/1ps
module uart_rx_status_test;

   localparam int DW    = 8;
   localparam int DEPTH = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          char_done = 1'b0;
   logic [DW-1:0] char_data = '0;
   logic          fifo_en = 1'b0;
   logic          data_rd = 1'b0;
   logic          lsr_rd = 1'b0;
   logic [DW-1:0] rd_data;
   logic          data_ready;
   logic          overrun_err;

   always #5 clk = ~clk;

   uart_rx_status #(.DATA_W(DW), .FIFO_DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_data(char_data),
      .fifo_en(fifo_en), .data_rd(data_rd), .lsr_rd(lsr_rd),
      .rd_data(rd_data), .data_ready(data_ready), .overrun_err(overrun_err)
   );

   int            checks = 0;
   int            errors = 0;
   logic [DW-1:0] exp_q[$];
   logic [DW-1:0] last_exp = '0;
   logic [DW-1:0] mon_e;
   logic          exp_ovr = 1'b0;
   logic          prev_fe = 1'b0;
   string         cur_tag = "R1";

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every data read (R10, R8)
   always @(negedge clk) begin
      #3;
      if (rst_n && data_rd) begin
         if (exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            chk(cur_tag, "rd_data", int'(rd_data), int'(mon_e));
            last_exp = mon_e;
         end else begin
            chk(cur_tag, "rd_data(empty)", int'(rd_data), int'(last_exp));
         end
      end
   end

   // driver: one cycle of stimulus, then the model update, then the flag check
   task automatic cyc(input logic ch, input logic [DW-1:0] b, input logic rd,
                      input logic lsr, input logic fe, input string tag);
      cur_tag   = tag;
      char_done = ch;
      char_data = b;
      data_rd   = rd;
      lsr_rd    = lsr;
      fifo_en   = fe;
      #4;
      if (lsr) exp_ovr = 1'b0;
      if (fe != prev_fe) begin
         exp_q.delete();               // R9 flush
         prev_fe = fe;
      end else if (ch) begin
         if (fe) begin
            if (exp_q.size() < DEPTH) exp_q.push_back(b);
            else exp_ovr = 1'b1;
         end else begin
            if (exp_q.size() == 0) exp_q.push_back(b);
            else begin
               exp_q[0] = b;
               exp_ovr  = 1'b1;
            end
         end
      end
      @(negedge clk);
      char_done = 1'b0;
      data_rd   = 1'b0;
      lsr_rd    = 1'b0;
      chk(tag, "data_ready", int'(data_ready), int'(exp_q.size() != 0));
      chk(tag, "overrun_err", int'(overrun_err), int'(exp_ovr));
   endtask

   bit done = 1'b0;

   initial begin
      #100000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "data_ready", int'(data_ready), 0);
      chk("R1", "overrun_err", int'(overrun_err), 0);
      chk("R1", "rd_data", int'(rd_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "data_ready", int'(data_ready), 0);

      // single-register mode
      cyc(1, 8'hA1, 0, 0, 0, "R2");
      cyc(0, 8'h00, 1, 0, 0, "R10");
      cyc(1, 8'hB1, 0, 0, 0, "R4");
      cyc(1, 8'hB2, 0, 0, 0, "R4");
      cyc(0, 8'h00, 1, 0, 0, "R4");
      cyc(0, 8'h00, 0, 1, 0, "R7");
      cyc(1, 8'hC1, 0, 0, 0, "R6");
      cyc(1, 8'hC2, 1, 0, 0, "R6");
      cyc(0, 8'h00, 1, 0, 0, "R6");
      cyc(0, 8'h00, 1, 0, 0, "R8");
      cyc(0, 8'h00, 1, 0, 0, "R8");
      cyc(1, 8'hD1, 0, 0, 0, "R8");
      cyc(0, 8'h00, 1, 0, 0, "R8");
      cyc(1, 8'hE1, 0, 0, 0, "R9");
      cyc(0, 8'h00, 0, 0, 1, "R9");
      cyc(0, 8'h00, 1, 0, 1, "R9");

      // queue mode: fill, overrun, set-wins, drain in order
      for (int i = 0; i < DEPTH; i++) cyc(1, 8'(8'h10 + i), 0, 0, 1, "R5");
      cyc(1, 8'h55, 0, 0, 1, "R5");
      cyc(1, 8'h66, 0, 1, 1, "R7");
      cyc(0, 8'h00, 0, 1, 1, "R7");
      for (int i = 0; i < DEPTH; i++) cyc(0, 8'h00, 1, 0, 1, "R3");

      // queue full, read and arrival together
      for (int i = 0; i < DEPTH; i++) cyc(1, 8'(8'h20 + i), 0, 0, 1, "R6");
      cyc(1, 8'h77, 1, 0, 1, "R6");
      for (int i = 0; i < DEPTH; i++) cyc(0, 8'h00, 1, 0, 1, "R3");
      cyc(0, 8'h00, 1, 0, 1, "R8");

      // back to single-register mode with data queued
      cyc(1, 8'h31, 0, 0, 1, "R9");
      cyc(1, 8'h32, 0, 0, 1, "R9");
      cyc(0, 8'h00, 0, 0, 0, "R9");
      cyc(0, 8'h00, 1, 0, 0, "R9");
      cyc(1, 8'hF1, 0, 0, 0, "R2");
      cyc(0, 8'h00, 1, 0, 0, "R10");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule